// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block gathers the interrupt events of a PCIe root-port bridge into a single level interrupt line for the host processor. Eleven sources feed it: six single-cycle transaction-error strobes (three on the AXI side, three on the PCIe side), four legacy INTx lines, and one summary level that is high while any MSI vector waits for service. Each event is latched into a sticky status register, and the status is qualified by an enable register. The output line rises while any enabled bit is pending.

Software uses a 32-bit register port. It enables sources through the enable register and reads the status register to learn which events are pending. It acknowledges an event by writing a 1 to that event's status bit. The status-bit layout is fixed because interrupt service code decodes it directly. Bits outside the defined set read as zero.

Top module: `pcie_rp_irq_agg`

## Requirements
- R1: After reset, the enable register (offset 0x180) and the status register (offset 0x184) both read zero, and `irq_o` is low.
- R2: Error strobe `err_i[i]` sets a status bit. For i = 0..2 (AXI post, fetch and discard) the bit is 16+i. For i = 3..5 (PCIe post, fetch and discard) the bit is 17+i, which gives bits 20..22.
- R3: Legacy line `intx_i[k]` (k = 0..3 for INTA..INTD) sets status bit 24+k.
- R4: The MSI summary input `msi_i` sets status bit 28.
- R5: A write to offset 0x184 clears each status bit whose data bit is 1 and leaves each status bit whose data bit is 0. Writing 0xFFFFFFFF clears every pending bit.
- R6: If an event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R7: A write to offset 0x180 stores only the defined bits (mask 0x1F770000). Reads of any other offset return zero, and writes to any other offset change neither register.
- R8: `irq_o` is a register. One cycle after any bit of (status AND enable) is nonzero, it is high. One cycle after that AND is zero, it is low.
- R9: With the enable register at zero, `irq_o` stays low while the status register still records events.
- R10: A status bit never becomes 1 except through an event. Writes to the status register cannot set bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, acted on at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| err_i | input | 6 | Error strobes: AXI post/fetch/discard, then PCIe post/fetch/discard |
| intx_i | input | 4 | Legacy INTA..INTD |
| msi_i | input | 1 | MSI-pending summary |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
A status bit that is lost or set wrongly shows up at once on a read of offset 0x184 in the cycle after the event or write. It also changes `irq_o` one cycle later whenever that bit is enabled. A corrupted enable bit stays hidden until a matching event arrives, so the stimulus keeps events, enable writes and clearing writes all active together. That way each wrong bit reaches either the read port or the interrupt line within two cycles.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;
    localparam int DATA_W       = 32;
    localparam int ERR_N        = 6;
    localparam int ERR_GRP      = 3;
    localparam int INTX_N       = 4;
    localparam int ERR_AXI_LSB  = 16;
    localparam int ERR_PCIE_LSB = 20;
    localparam int INTX_LSB     = 24;
    localparam int MSI_BIT      = 28;
    localparam logic [DATA_W-1:0] SRC_VALID = 32'h1F77_0000;

    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/irq_event_map.sv
module irq_event_map
    import pcie_irq_pkg::*;
(
    input  logic [ERR_N-1:0]  err_i,
    input  logic [INTX_N-1:0] intx_i,
    input  logic              msi_i,
    output word_t             ev_o
);
    always_comb begin
        ev_o = '0;
        for (int i = 0; i < ERR_N; i++) begin
            if (i < ERR_GRP) ev_o[ERR_AXI_LSB + i] = err_i[i];
            else             ev_o[ERR_PCIE_LSB + i - ERR_GRP] = err_i[i];
        end
        for (int k = 0; k < INTX_N; k++)
            ev_o[INTX_LSB + k] = intx_i[k];
        ev_o[MSI_BIT] = msi_i;
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import pcie_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t ev_i,
    input  logic  clr_en_i,
    input  word_t clr_bits_i,
    output word_t st_o
);
    typedef struct packed { word_t st; } st_state_t;
    st_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_en_i) s_d.st = s_d.st & ~clr_bits_i;
        s_d.st = (s_d.st | ev_i) & SRC_VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_o = s_q.st;

    // R6: an event always lands, even against a same-cycle clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((s_q.st & $past(ev_i)) == $past(ev_i)));
    // R10: no bit rises without an event
    a_r10_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.st & ~$past(s_q.st) & ~$past(ev_i)) == '0));
    // R5: cleared bits without a competing event are gone
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((s_q.st & $past(clr_bits_i) & ~$past(ev_i)) == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import pcie_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  word_t wdata_i,
    output word_t mask_o
);
    typedef struct packed { word_t mask; } mk_state_t;
    mk_state_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_i) m_d.mask = wdata_i & SRC_VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign mask_o = m_q.mask;

    // R7: enable register only moves on its own write
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(m_q.mask));
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
    import pcie_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t st_i,
    input  word_t mask_i,
    output logic  irq_o
);
    typedef struct packed { logic irq; } ln_state_t;
    ln_state_t l_d, l_q;

    always_comb begin
        l_d     = l_q;
        l_d.irq = |(st_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign irq_o = l_q.irq;

    // R9: an all-zero enable keeps the line quiet next cycle
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> !l_q.irq);
    // R8: no pending status means the line drops next cycle
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == '0) |=> !l_q.irq);
endmodule

// File: rtl/pcie_rp_irq_agg.sv
module pcie_rp_irq_agg
    import pcie_irq_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h180,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h184
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [5:0]        err_i,
    input  logic [3:0]        intx_i,
    input  logic              msi_i,
    output logic              irq_o
);
    word_t ev, st, mask;
    logic  sel_mask, sel_stat;

    assign sel_mask = (reg_addr == MASK_OFS);
    assign sel_stat = (reg_addr == STAT_OFS);

    irq_event_map u_map (
        .err_i (err_i), .intx_i (intx_i), .msi_i (msi_i), .ev_o (ev)
    );

    irq_status_reg u_stat (
        .clk (clk), .rst_n (rst_n), .ev_i (ev),
        .clr_en_i (reg_wr && sel_stat), .clr_bits_i (reg_wdata), .st_o (st)
    );

    irq_mask_reg u_mask (
        .clk (clk), .rst_n (rst_n), .wr_i (reg_wr && sel_mask),
        .wdata_i (reg_wdata), .mask_o (mask)
    );

    irq_line_gen u_line (
        .clk (clk), .rst_n (rst_n), .st_i (st), .mask_i (mask), .irq_o (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_mask)      reg_rdata = mask;
        else if (sel_stat) reg_rdata = st;
    end

    // R7: undefined bit positions never read back as one
    a_r7_undef_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((reg_rdata & ~SRC_VALID) == '0));
endmodule

// File: tb/test_pcie_rp_irq_agg.sv
module test_pcie_rp_irq_agg;
    localparam logic [11:0] A_MASK = 12'h180;
    localparam logic [11:0] A_STAT = 12'h184;
    localparam logic [31:0] VALID  = 32'h1F77_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  err_i = '0;
    logic [3:0]  intx_i = '0;
    logic        msi_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_st = '0, m_mask = '0;
    logic        m_irq = 1'b0;

    always #5 clk = ~clk;

    pcie_rp_irq_agg i_pcie_rp_irq_agg (
        .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
        .err_i, .intx_i, .msi_i, .irq_o
    );

    function automatic logic [31:0] ev_bits(logic [5:0] e, logic [3:0] x, logic m);
        logic [31:0] v = '0;
        for (int i = 0; i < 3; i++) begin
            v[16 + i] = e[i];
            v[20 + i] = e[3 + i];
        end
        for (int k = 0; k < 4; k++) v[24 + k] = x[k];
        v[28] = m;
        return v;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == A_MASK) return m_mask;
        if (a == A_STAT) return m_st;
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic [5:0] e, logic [3:0] x, logic m, logic w,
                       logic [11:0] a, logic [31:0] d, string tag);
        logic [31:0] st_n;
        @(negedge clk);
        err_i = e; intx_i = x; msi_i = m; reg_wr = w; reg_addr = a; reg_wdata = d;
        #1;
        check({tag, " read"}, reg_rdata, exp_read(a));
        check({tag, " R8 irq"}, {31'h0, irq_o}, {31'h0, m_irq});
        @(posedge clk);
        st_n = m_st;
        if (w && a == A_STAT) st_n = st_n & ~d;
        st_n = (st_n | ev_bits(e, x, m)) & VALID;
        m_irq = |(m_st & m_mask);
        if (w && a == A_MASK) m_mask = d & VALID;
        m_st = st_n;
    endtask

    task automatic rd(logic [11:0] a, string tag);
        cyc('0, '0, 1'b0, 1'b0, a, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] a;
        logic [31:0] d;
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        rd(A_MASK, "R1 mask reset");
        rd(A_STAT, "R1 stat reset");
        check("R1 irq reset", {31'h0, irq_o}, 32'h0);

        // R2: each error strobe alone
        for (int i = 0; i < 6; i++) begin
            cyc(6'(1 << i), '0, 1'b0, 1'b0, A_STAT, '0, "R2 strobe");
            rd(A_STAT, "R2 bit");
            cyc('0, '0, 1'b0, 1'b1, A_STAT, 32'hFFFF_FFFF, "R5 clear all");
        end
        // R3 and R4
        for (int k = 0; k < 4; k++) begin
            cyc('0, 4'(1 << k), 1'b0, 1'b0, A_STAT, '0, "R3 intx");
            rd(A_STAT, "R3 bit");
        end
        cyc('0, '0, 1'b1, 1'b0, A_STAT, '0, "R4 msi");
        rd(A_STAT, "R4 bit");
        // R5: partial clear, zeros keep
        cyc('0, '0, 1'b0, 1'b1, A_STAT, 32'h0100_0000, "R5 partial");
        rd(A_STAT, "R5 after partial");
        // R6: event meets clear on bit 25
        cyc('0, 4'b0010, 1'b0, 1'b1, A_STAT, 32'hFFFF_FFFF, "R6 collide");
        rd(A_STAT, "R6 kept");
        // R10: writing ones cannot set
        cyc('0, '0, 1'b0, 1'b1, A_STAT, 32'hFFFF_FFFF, "R10 clear");
        cyc('0, '0, 1'b0, 1'b1, A_STAT, 32'hFFFF_FFFF, "R10 ones");
        rd(A_STAT, "R10 empty");
        // R7: mask write, undefined bits, foreign offset
        cyc('0, '0, 1'b0, 1'b1, A_MASK, 32'hFFFF_FFFF, "R7 mask all");
        rd(A_MASK, "R7 mask valid bits");
        cyc('0, '0, 1'b0, 1'b1, 12'h188, 32'h0, "R7 foreign write");
        rd(A_MASK, "R7 mask unchanged");
        rd(12'h188, "R7 foreign read");
        // R8: enabled event raises irq two cycles later
        cyc(6'b000001, '0, 1'b0, 1'b0, A_STAT, '0, "R8 event");
        rd(A_STAT, "R8 pending");
        rd(A_STAT, "R8 high");
        cyc('0, '0, 1'b0, 1'b1, A_STAT, 32'hFFFF_FFFF, "R8 ack");
        rd(A_STAT, "R8 drop");
        rd(A_STAT, "R8 low");
        // R9: enable zero keeps irq low
        cyc('0, '0, 1'b0, 1'b1, A_MASK, 32'h0, "R9 mask off");
        cyc(6'h3F, 4'hF, 1'b1, 1'b0, A_STAT, '0, "R9 events");
        rd(A_STAT, "R9 status");
        rd(A_STAT, "R9 irq quiet");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            case ($urandom % 4)
                0: a = A_MASK;
                1, 2: a = A_STAT;
                default: a = 12'($urandom);
            endcase
            d = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
            cyc(($urandom % 4 == 0) ? 6'($urandom) : 6'h0,
                ($urandom % 4 == 0) ? 4'($urandom) : 4'h0,
                ($urandom % 5 == 0),
                ($urandom % 3 == 0), a, d, "R2 R3 R4 R5 R6 R7 R9 R10 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule